// File: doc/BRIEF.md
# Tag-Matching Reservation Station Array

This block holds a small pool of waiting operations in front of a single functional unit. An issue stage offers one operation per cycle. Each of its two source operands comes either as a finished value or as the tag of the station that will produce it. The pool keeps each accepted operation until both operands are known. A waiting operand is resolved by comparing its tag with every result that appears on a shared one-result-per-cycle broadcast bus. When the tags match, the entry copies the broadcast value. No central controller decides when an entry may run.

Once both operands of an entry are known, the entry may be dispatched to the functional unit. When several entries are ready in the same cycle, the one issued first goes first. Each entry has a fixed machine-wide tag. After dispatch, the entry stays occupied until the functional unit broadcasts a result carrying that tag, and only then does the entry become free. If every entry is occupied, the issue stage is told to hold.

Top module: `rsv_station_pool`

## Requirements
- R1: During reset and in the first cycle after it, all entries are free: `iss_ready` is 1 and `dsp_valid` is 0.
- R2: An issue is accepted on a clock edge where `iss_valid` and `iss_ready` are both 1. It is written into the lowest-numbered free entry. Entry i (counting from 0) carries tag `BASE_TAG + i`, which appears on `dsp_tag` when that entry is dispatched.
- R3: An operand issued with tag 0 is taken as valid at issue. That value, and the issued operation code, appear unchanged on `dsp_a`/`dsp_b` and `dsp_op`.
- R4: A waiting operand with a nonzero tag copies `bc_value` on an edge where `bc_valid` is 1 and `bc_tag` equals its tag, and its tag becomes 0. A broadcast with any other tag leaves the operand waiting.
- R5: If a broadcast arrives on the same edge as an issue and its tag matches an incoming operand's tag, the broadcast value is captured for that operand.
- R6: An entry is offered on `dsp_valid` only when both of its tags are 0. The offer appears in the cycle after the edge at which the last operand was resolved or issued.
- R7: Among ready entries, the one issued earliest is offered. If `dsp_ready` is 0, the offer stays valid.
- R8: An entry is launched on an edge where `dsp_valid` and `dsp_ready` are both 1, and it is never offered again. It stays occupied until a broadcast carries its own tag, and is free from the next cycle on.
- R9: When every entry is occupied, `iss_ready` is 0. An issue attempted while `iss_ready` is 0 is dropped and never appears at dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | A free entry exists |
| iss_op | input | OP_W | Operation code |
| iss_val_a | input | DATA_W | First operand value (used when its tag is 0) |
| iss_tag_a | input | TAG_W | First operand producer tag, 0 = valid |
| iss_val_b | input | DATA_W | Second operand value (used when its tag is 0) |
| iss_tag_b | input | TAG_W | Second operand producer tag, 0 = valid |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Tag of the broadcast producer |
| bc_value | input | DATA_W | Broadcast result value |
| dsp_valid | output | 1 | A ready entry is offered |
| dsp_ready | input | 1 | Functional unit takes the offer |
| dsp_op | output | OP_W | Offered operation code |
| dsp_a | output | DATA_W | Offered first operand |
| dsp_b | output | DATA_W | Offered second operand |
| dsp_tag | output | TAG_W | Tag of the offered entry |

## Verification
Every result of this block is a pure function of registered state, so each result is due exactly one edge after the stimulus that causes it. An issue with both operands valid, or a matching broadcast, shows up on the dispatch outputs in the following cycle. An entry's release shows up on `iss_ready` in the cycle after its own tag is broadcast. The bench drives inputs just after the falling edge and keeps a behavioural model that is updated at each rising edge. It compares all outputs at each falling edge, so every comparison sees the state that exactly one edge has produced. Directed checks sample at that same point, one step after the stimulus.

// File: rtl/rsp_pkg.sv
// Package: shared state encoding for the reservation station pool.
// Assumes nothing beyond a two-bit state per entry.
package rsp_pkg;

    // Life cycle of one entry: empty, waiting for operands/launch, launched
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_WAIT = 2'd1,
        SLOT_EXEC = 2'd2
    } slot_state_e;

endpackage

// File: rtl/rsp_free_pick.sv
// Module: rsp_free_pick
// Chooses the lowest-numbered free entry for an incoming issue.
// Assumes the caller gates the request with any_free; output is one-hot or zero.
module rsp_free_pick #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] free_vec,
    input  logic         req,
    output logic [N-1:0] alloc_vec,
    output logic         any_free
);

    // Priority search for the first free entry
    always_comb begin
        logic found;
        found     = 1'b0;
        alloc_vec = '0;
        for (int i = 0; i < N; i++) begin
            if (free_vec[i] && !found) begin
                alloc_vec[i] = req;
                found        = 1'b1;
            end
        end
        any_free = found;
    end

endmodule

// File: rtl/rsp_age_pick.sv
// Module: rsp_age_pick
// Keeps an age matrix (older_q[j][i] = entry j was issued before entry i)
// and grants the oldest ready entry. Assumes at most one allocation per cycle
// and that only occupied entries raise ready.
module rsp_age_pick #(
    parameter int unsigned N     = 4,
    parameter int unsigned IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     alloc_vec,
    input  logic [N-1:0]     ready_vec,
    output logic [N-1:0]     grant_vec,
    output logic [IDX_W-1:0] grant_idx,
    output logic             grant_any
);

    logic [N-1:0] older_q [N];

    // Age update: a new entry becomes younger than every other entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < N; j++) begin
                older_q[j] <= '0;
            end
        end else begin
            for (int k = 0; k < N; k++) begin
                if (alloc_vec[k]) begin
                    for (int j = 0; j < N; j++) begin
                        if (j != k) begin
                            older_q[j][k] <= 1'b1;
                            older_q[k][j] <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    // Grant an entry that is ready and has no older ready entry
    always_comb begin
        for (int i = 0; i < N; i++) begin
            logic blocked;
            blocked = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (j != i && ready_vec[j] && older_q[j][i]) begin
                    blocked = 1'b1;
                end
            end
            grant_vec[i] = ready_vec[i] && !blocked;
        end
    end

    // Encode the granted entry number
    always_comb begin
        grant_idx = '0;
        grant_any = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (grant_vec[i]) begin
                grant_idx = IDX_W'(i);
                grant_any = 1'b1;
            end
        end
    end

    // R7: at most one entry is granted in any cycle
    a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));

endmodule

// File: rtl/rsp_slot.sv
// Module: rsp_slot
// One reservation entry: stores an operation, two operands with producer tags,
// snoops the broadcast bus for its pending tags, and releases itself when a
// broadcast carries its own tag after launch. Assumes tag 0 means "valid".
module rsp_slot
    import rsp_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned OP_W   = 4,
    parameter int unsigned TAG_W  = 4,
    parameter int unsigned MY_TAG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [OP_W-1:0]   in_op,
    input  logic [DATA_W-1:0] in_val_a,
    input  logic [TAG_W-1:0]  in_tag_a,
    input  logic [DATA_W-1:0] in_val_b,
    input  logic [TAG_W-1:0]  in_tag_b,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value,
    input  logic              launch,
    output logic              is_free,
    output logic              is_ready,
    output logic [OP_W-1:0]   op,
    output logic [DATA_W-1:0] val_a,
    output logic [DATA_W-1:0] val_b
);

    localparam logic [TAG_W-1:0] OWN_TAG = TAG_W'(MY_TAG);

    slot_state_e       st_q;
    logic [TAG_W-1:0]  tag_a_q, tag_b_q;
    logic [OP_W-1:0]   op_q;
    logic [DATA_W-1:0] va_q, vb_q;

    logic hit_in_a, hit_in_b, hit_a, hit_b, hit_own;

    // Associative compares against the broadcast bus
    always_comb begin
        hit_in_a = (in_tag_a != '0) && bc_valid && (bc_tag == in_tag_a);
        hit_in_b = (in_tag_b != '0) && bc_valid && (bc_tag == in_tag_b);
        hit_a    = (tag_a_q  != '0) && bc_valid && (bc_tag == tag_a_q);
        hit_b    = (tag_b_q  != '0) && bc_valid && (bc_tag == tag_b_q);
        hit_own  = bc_valid && (bc_tag == OWN_TAG);
    end

    // Entry state, capture at issue, wakeup, launch and release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= SLOT_FREE;
            tag_a_q <= '0;
            tag_b_q <= '0;
            op_q    <= '0;
            va_q    <= '0;
            vb_q    <= '0;
        end else begin
            case (st_q)
                SLOT_FREE: begin
                    if (alloc) begin
                        st_q    <= SLOT_WAIT;
                        op_q    <= in_op;
                        va_q    <= hit_in_a ? bc_value : in_val_a;
                        tag_a_q <= hit_in_a ? '0 : in_tag_a;
                        vb_q    <= hit_in_b ? bc_value : in_val_b;
                        tag_b_q <= hit_in_b ? '0 : in_tag_b;
                    end
                end
                SLOT_WAIT: begin
                    if (hit_a) begin
                        va_q    <= bc_value;
                        tag_a_q <= '0;
                    end
                    if (hit_b) begin
                        vb_q    <= bc_value;
                        tag_b_q <= '0;
                    end
                    if (launch) begin
                        st_q <= SLOT_EXEC;
                    end
                end
                SLOT_EXEC: begin
                    if (hit_own) begin
                        st_q <= SLOT_FREE;
                    end
                end
                default: st_q <= SLOT_FREE;
            endcase
        end
    end

    // Status and payload toward the pickers and dispatch mux
    always_comb begin
        is_free  = (st_q == SLOT_FREE);
        is_ready = (st_q == SLOT_WAIT) && (tag_a_q == '0) && (tag_b_q == '0);
        op       = op_q;
        val_a    = va_q;
        val_b    = vb_q;
    end

    // R4: a matching broadcast resolves a waiting first operand
    a_r4_wake_a: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SLOT_WAIT && hit_a) |=> (tag_a_q == '0 && va_q == $past(bc_value)));

    // R4: without a match a pending second operand keeps its tag and value
    a_r4_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SLOT_WAIT && tag_b_q != '0 && !hit_b) |=> ($stable(tag_b_q) && $stable(vb_q)));

    // R2: allocation only lands on an empty entry
    a_r2_alloc_free_only: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> st_q == SLOT_FREE);

    // R6: launch only when both operands are resolved
    a_r6_launch_ready: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (st_q == SLOT_WAIT && tag_a_q == '0 && tag_b_q == '0));

endmodule

// File: rtl/rsv_station_pool.sv
// Module: rsv_station_pool (top)
// Pool of N_SLOTS reservation entries in front of one functional unit.
// Entry i answers to machine tag BASE_TAG+i; TAG_W must be wide enough for
// every producer tag in the machine. Assumes one broadcast per cycle.
module rsv_station_pool
    import rsp_pkg::*;
#(
    parameter int unsigned N_SLOTS  = 4,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned OP_W     = 4,
    parameter int unsigned TAG_W    = 4,
    parameter int unsigned BASE_TAG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    output logic              iss_ready,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [DATA_W-1:0] iss_val_a,
    input  logic [TAG_W-1:0]  iss_tag_a,
    input  logic [DATA_W-1:0] iss_val_b,
    input  logic [TAG_W-1:0]  iss_tag_b,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value,
    output logic              dsp_valid,
    input  logic              dsp_ready,
    output logic [OP_W-1:0]   dsp_op,
    output logic [DATA_W-1:0] dsp_a,
    output logic [DATA_W-1:0] dsp_b,
    output logic [TAG_W-1:0]  dsp_tag
);

    localparam int unsigned IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;

    logic [N_SLOTS-1:0] free_vec, ready_vec, alloc_vec, grant_vec, launch_vec;
    logic [IDX_W-1:0]   grant_idx;
    logic               grant_any, any_free;
    logic [OP_W-1:0]    s_op [N_SLOTS];
    logic [DATA_W-1:0]  s_va [N_SLOTS];
    logic [DATA_W-1:0]  s_vb [N_SLOTS];

    rsp_free_pick #(.N(N_SLOTS)) i_free_pick (
        .free_vec (free_vec),
        .req      (iss_valid),
        .alloc_vec(alloc_vec),
        .any_free (any_free)
    );

    rsp_age_pick #(.N(N_SLOTS), .IDX_W(IDX_W)) i_age_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_vec(alloc_vec),
        .ready_vec(ready_vec),
        .grant_vec(grant_vec),
        .grant_idx(grant_idx),
        .grant_any(grant_any)
    );

    // Launch the granted entry when the functional unit accepts
    always_comb begin
        launch_vec = grant_vec & {N_SLOTS{dsp_ready}};
    end

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        rsp_slot #(
            .DATA_W(DATA_W),
            .OP_W  (OP_W),
            .TAG_W (TAG_W),
            .MY_TAG(BASE_TAG + g)
        ) i_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .alloc   (alloc_vec[g]),
            .in_op   (iss_op),
            .in_val_a(iss_val_a),
            .in_tag_a(iss_tag_a),
            .in_val_b(iss_val_b),
            .in_tag_b(iss_tag_b),
            .bc_valid(bc_valid),
            .bc_tag  (bc_tag),
            .bc_value(bc_value),
            .launch  (launch_vec[g]),
            .is_free (free_vec[g]),
            .is_ready(ready_vec[g]),
            .op      (s_op[g]),
            .val_a   (s_va[g]),
            .val_b   (s_vb[g])
        );
    end

    // Issue handshake and dispatch payload from the granted entry
    always_comb begin
        iss_ready = any_free;
        dsp_valid = grant_any;
        dsp_op    = s_op[grant_idx];
        dsp_a     = s_va[grant_idx];
        dsp_b     = s_vb[grant_idx];
        dsp_tag   = TAG_W'(BASE_TAG) + TAG_W'(grant_idx);
    end

    // R7: an unaccepted offer is still present next cycle
    a_r7_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_valid && !dsp_ready) |=> dsp_valid);

    // R8: a launched entry is not offered in the following cycle
    a_r8_no_reoffer: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_valid && dsp_ready) |=> !(dsp_valid && dsp_tag == $past(dsp_tag)));

    // R9: nothing is allocated while the pool reports full
    a_r9_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_ready |-> alloc_vec == '0);

endmodule

// File: tb/test_rsv_station_pool.sv
`timescale 1ns/100ps
module test_rsv_station_pool;

    localparam int N = 4;
    localparam int BASE = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic        iss_ready;
    logic [3:0]  iss_op = '0;
    logic [31:0] iss_val_a = '0;
    logic [3:0]  iss_tag_a = '0;
    logic [31:0] iss_val_b = '0;
    logic [3:0]  iss_tag_b = '0;
    logic        bc_valid = 1'b0;
    logic [3:0]  bc_tag = '0;
    logic [31:0] bc_value = '0;
    logic        dsp_valid;
    logic        dsp_ready = 1'b0;
    logic [3:0]  dsp_op;
    logic [31:0] dsp_a, dsp_b;
    logic [3:0]  dsp_tag;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rsv_station_pool i_rsv_station_pool (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
        .iss_val_a(iss_val_a), .iss_tag_a(iss_tag_a),
        .iss_val_b(iss_val_b), .iss_tag_b(iss_tag_b),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
        .dsp_valid(dsp_valid), .dsp_ready(dsp_ready), .dsp_op(dsp_op),
        .dsp_a(dsp_a), .dsp_b(dsp_b), .dsp_tag(dsp_tag)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model: 0 free, 1 waiting, 2 launched
    int          m_st  [N];
    logic [3:0]  m_op  [N];
    logic [31:0] m_va  [N];
    logic [31:0] m_vb  [N];
    logic [3:0]  m_ta  [N];
    logic [3:0]  m_tb  [N];
    int          m_seq [N];
    int          seq_ctr = 0;

    function automatic int model_free();
        for (int i = 0; i < N; i++) if (m_st[i] == 0) return i;
        return -1;
    endfunction

    function automatic int model_pick();
        int best = -1;
        for (int i = 0; i < N; i++) begin
            if (m_st[i] == 1 && m_ta[i] == 0 && m_tb[i] == 0) begin
                if (best < 0 || m_seq[i] < m_seq[best]) best = i;
            end
        end
        return best;
    endfunction

    // Model update at each rising edge from the inputs driven before it
    always @(posedge clk) begin
        int pre [N];
        int fr, pk;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_st[i] = 0; m_ta[i] = 0; m_tb[i] = 0; m_op[i] = 0;
                m_va[i] = 0; m_vb[i] = 0; m_seq[i] = 0;
            end
        end else begin
            for (int i = 0; i < N; i++) pre[i] = m_st[i];
            fr = model_free();
            pk = model_pick();
            for (int i = 0; i < N; i++) begin
                if (pre[i] == 1) begin
                    if (m_ta[i] != 0 && bc_valid && bc_tag == m_ta[i]) begin m_va[i] = bc_value; m_ta[i] = 0; end
                    if (m_tb[i] != 0 && bc_valid && bc_tag == m_tb[i]) begin m_vb[i] = bc_value; m_tb[i] = 0; end
                end
                if (pre[i] == 2 && bc_valid && bc_tag == 4'(BASE + i)) m_st[i] = 0;
            end
            if (pk >= 0 && dsp_ready) m_st[pk] = 2;
            if (iss_valid && fr >= 0) begin
                m_st[fr] = 1;
                m_op[fr] = iss_op;
                m_seq[fr] = seq_ctr++;
                if (iss_tag_a != 0 && bc_valid && bc_tag == iss_tag_a) begin m_va[fr] = bc_value; m_ta[fr] = 0; end
                else begin m_va[fr] = iss_val_a; m_ta[fr] = iss_tag_a; end
                if (iss_tag_b != 0 && bc_valid && bc_tag == iss_tag_b) begin m_vb[fr] = bc_value; m_tb[fr] = 0; end
                else begin m_vb[fr] = iss_val_b; m_tb[fr] = iss_tag_b; end
            end
        end
    end

    // Compare all outputs against the model at every falling edge
    always @(negedge clk) begin
        int pk;
        if (rst_n && !done) begin
            pk = model_pick();
            chk(iss_ready == (model_free() >= 0), "R9 iss_ready", 32'(iss_ready), 32'(model_free() >= 0));
            chk(dsp_valid == (pk >= 0), "R6 dsp_valid", 32'(dsp_valid), 32'(pk >= 0));
            if (pk >= 0 && dsp_valid) begin
                chk(dsp_tag == 4'(BASE + pk), "R7 dsp_tag", 32'(dsp_tag), 32'(BASE + pk));
                chk(dsp_op == m_op[pk], "R3 dsp_op", 32'(dsp_op), 32'(m_op[pk]));
                chk(dsp_a == m_va[pk], "R4 dsp_a", dsp_a, m_va[pk]);
                chk(dsp_b == m_vb[pk], "R4 dsp_b", dsp_b, m_vb[pk]);
            end
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic put(input logic [3:0] op, input logic [31:0] va, input logic [3:0] ta,
                       input logic [31:0] vb, input logic [3:0] tb);
        iss_valid = 1'b1; iss_op = op;
        iss_val_a = va; iss_tag_a = ta; iss_val_b = vb; iss_tag_b = tb;
    endtask

    task automatic bcast(input logic [3:0] t, input logic [31:0] v);
        bc_valid = 1'b1; bc_tag = t; bc_value = v;
    endtask

    task automatic idle();
        iss_valid = 1'b0; bc_valid = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin : main
        repeat (3) step();
        chk(iss_ready == 1'b1, "R1 iss_ready in reset", 32'(iss_ready), 1);
        chk(dsp_valid == 1'b0, "R1 dsp_valid in reset", 32'(dsp_valid), 0);
        rst_n = 1'b1;
        step();
        chk(iss_ready == 1'b1 && dsp_valid == 1'b0, "R1 after reset", {iss_ready, dsp_valid}, 32'b10);

        // R2/R3: both operands valid at issue, lands in entry 0 (tag 1)
        put(4'd3, 32'd11, 4'd0, 32'd22, 4'd0);
        step();
        idle();
        chk(dsp_valid == 1'b1, "R6 offer next cycle", 32'(dsp_valid), 1);
        chk(dsp_tag == 4'd1, "R2 first entry tag", 32'(dsp_tag), 1);
        chk(dsp_a == 32'd11 && dsp_b == 32'd22, "R3 operands", dsp_a, 32'd11);
        chk(dsp_op == 4'd3, "R3 op", 32'(dsp_op), 3);

        // R5: broadcast in the issue cycle matches the incoming first tag
        put(4'd5, 32'd0, 4'd6, 32'd33, 4'd0);
        bcast(4'd6, 32'd77);
        step();
        idle();
        chk(dsp_tag == 4'd1, "R7 oldest stays offered", 32'(dsp_tag), 1);
        dsp_ready = 1'b1;
        step();
        dsp_ready = 1'b0;
        chk(dsp_tag == 4'd2, "R2 second entry tag", 32'(dsp_tag), 2);
        chk(dsp_a == 32'd77, "R5 same-cycle capture", dsp_a, 32'd77);

        // R4/R6/R8: third entry waits on tag 9
        dsp_ready = 1'b1;
        put(4'd7, 32'd0, 4'd9, 32'd44, 4'd0);
        step();
        dsp_ready = 1'b0;
        idle();
        chk(dsp_valid == 1'b0, "R8 launched entries not reoffered", 32'(dsp_valid), 0);
        bcast(4'd8, 32'd1);
        step();
        idle();
        chk(dsp_valid == 1'b0, "R4 other tag ignored", 32'(dsp_valid), 0);
        bcast(4'd9, 32'd99);
        step();
        idle();
        chk(dsp_valid == 1'b1 && dsp_tag == 4'd3, "R6 ready after wakeup", 32'(dsp_tag), 3);
        chk(dsp_a == 32'd99 && dsp_b == 32'd44, "R4 captured value", dsp_a, 32'd99);

        // R9: fill the last entry, then try to issue while full
        put(4'd9, 32'd1, 4'd0, 32'd2, 4'd0);
        step();
        chk(iss_ready == 1'b0, "R9 full", 32'(iss_ready), 0);
        put(4'd15, 32'hdead, 4'd0, 32'hbeef, 4'd0);
        step();
        idle();
        bcast(4'd1, 32'd5);
        step();
        idle();
        chk(iss_ready == 1'b1, "R8 release by own tag", 32'(iss_ready), 1);
        chk(dsp_tag == 4'd3, "R7 oldest of two ready", 32'(dsp_tag), 3);
        dsp_ready = 1'b1;
        step();
        step();
        dsp_ready = 1'b0;
        chk(dsp_valid == 1'b0, "R9 dropped issue never offered", 32'(dsp_valid), 0);

        // Mixed traffic checked against the model each cycle
        for (int c = 0; c < 4000; c++) begin
            iss_valid = ($urandom % 2) == 0;
            iss_op    = 4'($urandom);
            iss_val_a = $urandom;
            iss_val_b = $urandom;
            iss_tag_a = ($urandom % 3 == 0) ? 4'd0 : 4'(1 + $urandom % 7);
            iss_tag_b = ($urandom % 3 == 0) ? 4'd0 : 4'(1 + $urandom % 7);
            bc_valid  = ($urandom % 5) < 3;
            bc_tag    = 4'(1 + $urandom % 7);
            bc_value  = $urandom;
            dsp_ready = ($urandom % 10) < 7;
            step();
        end
        idle();
        dsp_ready = 1'b0;
        step();
        finish_run();
    end

endmodule